// File: doc/BRIEF.md
# Reset/NMI Pin Role Controller

This block sits in the system-control area of a chip. It decides what one external pin does. By default the pin is a reset input: a low level on it raises a reset request toward the reset logic. Software can instead give the pin the role of an edge-triggered non-maskable interrupt source. In that role a selectable edge sets a sticky flag, and an enable bit passes the flag on as an interrupt request.

The same register space holds the pull-resistor controls for the pin and a lock bit for the shared debug pins. The pull controls are a direction bit and an enable bit, and both are driven straight to outputs. The lock bit moves the shared debug pins into four-wire JTAG mode. Software can only set it. Only the brown-out reset input clears it.

Software reaches every bit through a small register port with an address, a write strobe, write data and combinational read data. The raw pin passes through a level synchronizer before any logic uses it.

Top module: `rstnmi_pinctl`

## Requirements
- R1: While `bor_n_i` is low and after it is released, every register bit reads 0. This means reset role, rising edge selected, pull-down selected, pull disabled, interrupt disabled, flag clear and JTAG lock clear. `rst_req_o`, `nmi_irq_o`, `pull_up_o`, `pull_en_o` and `jtag_mode_o` are all 0.
- R2: Register layout. Address 0: bit0 is the NMI role (1 = NMI, 0 = reset), bit1 is the edge select (1 = falling, 0 = rising), bit2 is the pull direction (1 = up, 0 = down), bit3 is the pull enable. Address 1: bit0 is the interrupt enable, bit1 is the NMI flag. Address 2: bit0 is the JTAG lock. Address 3 and all unlisted bits read 0. `rdata_o` shows the current register values combinationally.
- R3: `pull_up_o` and `pull_en_o` follow their register bits from the clock edge that performs the write.
- R4: In the reset role, `rst_req_o` is 1 exactly when the synchronized pin is low. A pin change appears on `rst_req_o` after the second rising clock edge. No NMI flag is set in the reset role.
- R5: In the NMI role, `rst_req_o` stays 0. The selected edge on the pin sets the flag on the third rising clock edge after the pin changes.
- R6: Only the selected edge sets the flag. With rising selected, a high-to-low change has no effect, and with falling selected, a low-to-high change has no effect.
- R7: `nmi_irq_o` is 1 exactly when both the flag and the interrupt enable are 1.
- R8: Writing 0 to the flag bit clears it, and writing 1 leaves it unchanged. If a detected edge and a clearing write fall on the same clock edge, the flag ends up set.
- R9: Writing the role bit or the edge-select bit while the pin is held steady never sets the flag.
- R10: Writing 1 to the JTAG lock sets `jtag_mode_o`, and writing 0 has no effect. Only `bor_n_i` low clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| bor_n_i | input | 1 | Brown-out reset, active low, asynchronous; clears all state |
| addr_i | input | ADDR_W | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| pin_i | input | 1 | Raw level of the external reset/NMI pin |
| rst_req_o | output | 1 | Reset request, active high |
| nmi_irq_o | output | 1 | NMI interrupt request |
| pull_up_o | output | 1 | Pull direction: 1 up, 0 down |
| pull_en_o | output | 1 | Pull resistor enable |
| jtag_mode_o | output | 1 | Shared debug pins in four-wire JTAG mode |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 2-bit address and a two-stage synchronizer. With these values every register, including the empty fourth address, can be read back. The two-stage depth fixes the exact cycle on which `rst_req_o` and the NMI flag move after a pin change. Because that timing is exact, the bench can line up a clearing write with a detected edge on the same clock edge and test the set-wins priority directly.

// File: rtl/rstnmi_pkg.sv
package rstnmi_pkg;

    localparam int unsigned REG_CTRL = 0;
    localparam int unsigned REG_IRQ  = 1;
    localparam int unsigned REG_JTAG = 2;

    localparam int unsigned B_ROLE  = 0;
    localparam int unsigned B_FALL  = 1;
    localparam int unsigned B_UP    = 2;
    localparam int unsigned B_PEN   = 3;
    localparam int unsigned B_IE    = 0;
    localparam int unsigned B_FLAG  = 1;
    localparam int unsigned B_LOCK  = 0;

    typedef struct packed {
        logic nmi_role;
        logic edge_fall;
        logic pull_up;
        logic pull_en;
        logic nmi_ie;
        logic nmi_flag;
        logic jtag_lock;
    } pinctl_regs_t;

    localparam pinctl_regs_t REGS_RST = '0;

endpackage

// File: rtl/rstnmi_sync.sv
module rstnmi_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d_i;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) chain_q <= {STAGES{RST_VAL}};
        else          chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rstnmi_edge.sv
module rstnmi_edge (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic lvl_i,
    input  logic arm_i,
    input  logic fall_i,
    output logic evt_o
);

    logic hist_d, hist_q;
    logic rose, fell;

    always_comb begin
        hist_d = lvl_i;
        rose   = lvl_i & ~hist_q;
        fell   = ~lvl_i & hist_q;
        evt_o  = arm_i & (fall_i ? fell : rose);
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) hist_q <= 1'b1;
        else          hist_q <= hist_d;
    end

endmodule

// File: rtl/rstnmi_pinctl.sv
module rstnmi_pinctl
    import rstnmi_pkg::*;
#(
    parameter int unsigned ADDR_W      = 2,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              bor_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              pin_i,
    output logic              rst_req_o,
    output logic              nmi_irq_o,
    output logic              pull_up_o,
    output logic              pull_en_o,
    output logic              jtag_mode_o
);

    localparam int unsigned MIN_W = 4;

    pinctl_regs_t r_d, r_q;
    logic         pin_sync;
    logic         edge_evt;
    logic         flag_clr;

    rstnmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (bor_n_i),
        .d_i     (pin_i),
        .q_o     (pin_sync)
    );

    rstnmi_edge u_edge (
        .clk_i   (clk_i),
        .rst_n_i (bor_n_i),
        .lvl_i   (pin_sync),
        .arm_i   (r_q.nmi_role),
        .fall_i  (r_q.edge_fall),
        .evt_o   (edge_evt)
    );

    generate
        if (DATA_W < MIN_W) begin : g_bad_width
            initial $error("DATA_W too small for control register");
        end
    endgenerate

    always_comb begin
        r_d      = r_q;
        flag_clr = wr_en_i && (addr_i == ADDR_W'(REG_IRQ)) && !wdata_i[B_FLAG];

        if (wr_en_i) begin
            case (addr_i)
                ADDR_W'(REG_CTRL): begin
                    r_d.nmi_role  = wdata_i[B_ROLE];
                    r_d.edge_fall = wdata_i[B_FALL];
                    r_d.pull_up   = wdata_i[B_UP];
                    r_d.pull_en   = wdata_i[B_PEN];
                end
                ADDR_W'(REG_IRQ): begin
                    r_d.nmi_ie = wdata_i[B_IE];
                end
                ADDR_W'(REG_JTAG): begin
                    if (wdata_i[B_LOCK]) r_d.jtag_lock = 1'b1;
                end
                default: ;
            endcase
        end

        // set has priority over a same-cycle clear
        r_d.nmi_flag = edge_evt | (r_q.nmi_flag & ~flag_clr);
    end

    always_ff @(posedge clk_i or negedge bor_n_i) begin
        if (!bor_n_i) r_q <= REGS_RST;
        else          r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_W'(REG_CTRL): begin
                rdata_o[B_ROLE] = r_q.nmi_role;
                rdata_o[B_FALL] = r_q.edge_fall;
                rdata_o[B_UP]   = r_q.pull_up;
                rdata_o[B_PEN]  = r_q.pull_en;
            end
            ADDR_W'(REG_IRQ): begin
                rdata_o[B_IE]   = r_q.nmi_ie;
                rdata_o[B_FLAG] = r_q.nmi_flag;
            end
            ADDR_W'(REG_JTAG): rdata_o[B_LOCK] = r_q.jtag_lock;
            default: ;
        endcase
    end

    assign rst_req_o   = ~r_q.nmi_role & ~pin_sync;
    assign nmi_irq_o   = r_q.nmi_flag & r_q.nmi_ie;
    assign pull_up_o   = r_q.pull_up;
    assign pull_en_o   = r_q.pull_en;
    assign jtag_mode_o = r_q.jtag_lock;

endmodule

// File: rtl/rstnmi_pinctl_chk.sv
module rstnmi_pinctl_chk (
    input logic clk_i,
    input logic bor_n_i,
    input logic wr_en_i,
    input logic rst_req_o,
    input logic pull_up_o,
    input logic pull_en_o,
    input logic jtag_mode_o,
    input logic flag_i,
    input logic evt_i
);

    // R10
    jtag_sticky_chk: assert property (@(posedge clk_i) disable iff (!bor_n_i)
        jtag_mode_o |=> jtag_mode_o);

    // R4
    reset_role_no_evt_chk: assert property (@(posedge clk_i) disable iff (!bor_n_i)
        rst_req_o |-> !evt_i);

    // R3
    pull_by_write_chk: assert property (@(posedge clk_i) disable iff (!bor_n_i)
        (!$stable(pull_up_o) || !$stable(pull_en_o)) |-> $past(wr_en_i));

    // R5
    flag_from_edge_chk: assert property (@(posedge clk_i) disable iff (!bor_n_i)
        $rose(flag_i) |-> $past(evt_i));

    // R8
    flag_clear_by_write_chk: assert property (@(posedge clk_i) disable iff (!bor_n_i)
        $fell(flag_i) |-> $past(wr_en_i));

endmodule

bind rstnmi_pinctl rstnmi_pinctl_chk u_chk (
    .clk_i       (clk_i),
    .bor_n_i     (bor_n_i),
    .wr_en_i     (wr_en_i),
    .rst_req_o   (rst_req_o),
    .pull_up_o   (pull_up_o),
    .pull_en_o   (pull_en_o),
    .jtag_mode_o (jtag_mode_o),
    .flag_i      (r_q.nmi_flag),
    .evt_i       (edge_evt)
);

// File: tb/sim_rstnmi_pinctl.sv
module sim_rstnmi_pinctl;

    logic       clk = 1'b0;
    logic       bor_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       pin = 1'b1;
    logic       rst_req, nmi_irq, pull_up, pull_en, jtag_mode;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rstnmi_pinctl u0 (
        .clk_i(clk), .bor_n_i(bor_n), .addr_i(addr), .wr_en_i(wr_en),
        .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .rst_req_o(rst_req),
        .nmi_irq_o(nmi_irq), .pull_up_o(pull_up), .pull_en_o(pull_en),
        .jtag_mode_o(jtag_mode)
    );

    // behavioural reference
    bit m_role, m_fall, m_up, m_pen, m_ie, m_flag, m_lock;
    bit pq[$] = '{1'b1, 1'b1, 1'b1};

    always @(posedge clk) begin
        if (!bor_n) begin
            {m_role, m_fall, m_up, m_pen, m_ie, m_flag, m_lock} = '0;
            pq = '{1'b1, 1'b1, 1'b1};
        end else begin
            bit ev;
            bit clr;
            ev  = m_role && (m_fall ? (pq[0] && !pq[1]) : (!pq[0] && pq[1]));
            clr = wr_en && addr == 2'd1 && !wdata[1];
            if (wr_en) begin
                if (addr == 2'd0) {m_pen, m_up, m_fall, m_role} = wdata[3:0];
                if (addr == 2'd1) m_ie = wdata[0];
                if (addr == 2'd2 && wdata[0]) m_lock = 1'b1;
            end
            m_flag = ev || (m_flag && !clr);
            pq.push_back(pin);
            void'(pq.pop_front());
        end
    end

    function automatic logic [7:0] model_rd(input logic [1:0] a);
        case (a)
            2'd0: return {4'b0, m_pen, m_up, m_fall, m_role};
            2'd1: return {6'b0, m_flag, m_ie};
            2'd2: return {7'b0, m_lock};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R2 rdata", rdata, model_rd(addr));
        check("R4 rst_req", {7'b0, rst_req}, {7'b0, (!m_role && !pq[1])});
        check("R7 nmi_irq", {7'b0, nmi_irq}, {7'b0, (m_flag && m_ie)});
        check("R3 pull_up", {7'b0, pull_up}, {7'b0, m_up});
        check("R3 pull_en", {7'b0, pull_en}, {7'b0, m_pen});
        check("R10 jtag", {7'b0, jtag_mode}, {7'b0, m_lock});
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        addr = a;
        step();
        check(tag, rdata, exp);
    endtask

    initial begin
        @(negedge clk);
        step(3);
        // R1 reset state
        check("R1 rst_req", {7'b0, rst_req}, 8'h00);
        check("R1 outputs", {4'b0, nmi_irq, pull_up, pull_en, jtag_mode}, 8'h00);
        bor_n = 1'b1;
        expect_rd(2'd0, 8'h00, "R1 ctrl");
        expect_rd(2'd1, 8'h00, "R1 irq");
        expect_rd(2'd2, 8'h00, "R1 jtag");
        expect_rd(2'd3, 8'h00, "R2 empty addr");

        // R3 pulls
        wr(2'd0, 8'h0C);
        check("R3 pull up+en", {6'b0, pull_up, pull_en}, 8'h03);
        wr(2'd0, 8'hF8);
        check("R3 pull down+en", {6'b0, pull_up, pull_en}, 8'h01);
        expect_rd(2'd0, 8'h08, "R2 unused bits");

        // R4 reset role
        pin = 1'b0;
        step(1);
        check("R4 not yet", {7'b0, rst_req}, 8'h00);
        step(1);
        check("R4 asserted", {7'b0, rst_req}, 8'h01);
        step(2);
        expect_rd(2'd1, 8'h00, "R4 no flag");
        pin = 1'b1;
        step(3);
        check("R4 released", {7'b0, rst_req}, 8'h00);

        // R9 role / edge change with steady low pin
        pin = 1'b0;
        step(4);
        wr(2'd0, 8'h01);
        step(2);
        wr(2'd0, 8'h03);
        step(2);
        wr(2'd0, 8'h01);
        step(2);
        expect_rd(2'd1, 8'h00, "R9 no event");
        check("R5 no rst_req in NMI role", {7'b0, rst_req}, 8'h00);

        // R5 rising edge sets flag on third edge
        pin = 1'b1;
        step(2);
        expect_rd(2'd1, 8'h02, "R5 flag set");

        // R8 write 1 keeps, write 0 clears
        wr(2'd1, 8'h02);
        expect_rd(2'd1, 8'h02, "R8 write 1 no effect");
        wr(2'd1, 8'h00);
        expect_rd(2'd1, 8'h00, "R8 cleared");

        // R7 enable gating
        wr(2'd1, 8'h01);
        check("R7 no flag", {7'b0, nmi_irq}, 8'h00);
        pin = 1'b0; step(4);
        pin = 1'b1; step(4);
        check("R7 irq", {7'b0, nmi_irq}, 8'h01);
        wr(2'd1, 8'h00);
        check("R7 disabled", {7'b0, nmi_irq}, 8'h00);
        wr(2'd1, 8'h01);

        // R6 wrong edge ignored
        pin = 1'b0; step(4);
        expect_rd(2'd1, 8'h01, "R6 falling ignored in rising mode");
        wr(2'd0, 8'h03);
        pin = 1'b1; step(4);
        expect_rd(2'd1, 8'h01, "R6 rising ignored in falling mode");
        pin = 1'b0; step(4);
        expect_rd(2'd1, 8'h03, "R6 falling detected");

        // R8 set wins over same-cycle clear
        wr(2'd1, 8'h01);
        pin = 1'b1; step(4);
        expect_rd(2'd1, 8'h01, "R8 cleared before race");
        pin = 1'b0;
        step(2);
        wr(2'd1, 8'h01);
        expect_rd(2'd1, 8'h03, "R8 set wins");

        // R10 write-once lock
        wr(2'd2, 8'h01);
        check("R10 set", {7'b0, jtag_mode}, 8'h01);
        wr(2'd2, 8'h00);
        expect_rd(2'd2, 8'h01, "R10 write 0 ignored");
        bor_n = 1'b0;
        step(2);
        check("R10 cleared by bor", {7'b0, jtag_mode}, 8'h00);
        bor_n = 1'b1;
        step(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule